// File: doc/BRIEF.md
# Programmable Count Channel

This block is a single programmable down-counter channel. It counts on clock cycles in which a count-enable strobe is high, and a gate input controls it. A configuration write supplies a new initial count, an operating mode and a decimal/binary selector. In response, the channel produces a live count value and one output level. The six modes differ in three ways: whether the counter wraps past zero or reloads itself, whether the gate pauses counting or retriggers it, and what shape the output takes (a latched terminal flag, a one-shot pulse, a rate divider, a square wave, or a single strobe).

A larger timer macro places one instance per channel and sequences host bytes into `load_value` on its own side. The configuration path is a single strobe, `load_valid`. The channel takes it in the cycle it is high. There is no ready signal, so the channel never applies back-pressure, and a load always overrides any counting in that cycle. A "tick" below means a clock edge that samples `tick_en` high. Both outputs are registered and change at that edge.

Top module: `prog_count_channel`

## Requirements
- R1: After reset, `count_out` is 0 and `out_level` is 0. Ticks and gate activity have no effect until the first load. The internal gate history resets to `GATE_RST`, so a gate held high from reset is not a rising edge.
- R2: A loaded value of 0 means the full span: 65536 in binary and 10000 in decimal. It shows as 0x0000 right after the load, and the first tick gives 0xFFFF (binary) or 0x9999 (decimal).
- R3: With `load_bcd`=1, `load_value` is read as four decimal digits, one per nibble, and `count_out` is presented as four decimal digits. Decrements borrow across digits (0x0010 becomes 0x0009).
- R4: In modes 0, 1, 4 and 5, a tick at count 0 gives 0xFFFF (binary) or 0x9999 (decimal), and counting continues from there.
- R5: Mode 0: a load drives the output low. The output goes high at the tick where the count reaches 0 and stays high until the next load.
- R6: Mode 1: the output is high from a load or retrigger. It goes low at the tick where the count reaches 0 and stays low until the next load or retrigger.
- R7: Mode 2, count N: the tick that takes the count from 1 reloads N and raises the output, and the next tick lowers it. This gives one high tick every N ticks.
- R8: Mode 3, count N: the count drops by 2 per tick. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks of each N-tick period. An even N loads N, an odd N loads N+1 in the high half, and N=1 keeps the output high.
- R9: Modes 4 and 5: the output is a strobe that is high for exactly one tick, when the count first reaches 0 after a load or retrigger. After the count wraps it stays low.
- R10: In modes 0 and 4, a low gate freezes the count and the output.
- R11: In modes 1, 2, 3 and 5, a rising gate edge restarts the channel from its initial count. In modes 0 and 4, a rising gate edge has no restart effect.
- R12: Mode codes 6 and 7 behave as modes 2 and 3. Any load restarts the channel from the new count, including a load while the channel is already counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-clock enable, one tick per high cycle |
| gate_in | input | 1 | Gate level, used as an enable or a trigger depending on mode |
| load_valid | input | 1 | Configuration strobe, always accepted |
| load_value | input | CNT_W | Initial count (binary or four decimal digits) |
| load_mode | input | 3 | Mode code 0..7 |
| load_bcd | input | 1 | 1 selects decimal counting |
| count_out | output | CNT_W | Live count in the selected number format |
| out_level | output | 1 | Channel output waveform |

## Verification
A wrong reload or wrap value shows in `count_out` at the same tick it happens, and it moves every later reading off the expected sequence. A wrong phase or armed flag shows up later, at the next terminal tick. There the output fails to rise, rises a second time after a wrap, or the square-wave halves come out of balance. The gate cases separate "freeze" from "restart" in the first cycle after the edge, because the count either holds or jumps back to its initial value.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
  typedef enum logic [2:0] {
    MD_TERMINAL    = 3'd0,
    MD_ONESHOT     = 3'd1,
    MD_DIVIDER     = 3'd2,
    MD_SQUARE      = 3'd3,
    MD_SOFT_STROBE = 3'd4,
    MD_GATE_STROBE = 3'd5
  } pcc_mode_e;

  function automatic int unsigned pow10(input int n);
    int unsigned r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/pcc_load_decode.sv
`timescale 1ns/1ps
module pcc_load_decode
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int CW = CNT_W + 1,
  localparam int DIG = CNT_W / 4
) (
  input  logic [CNT_W-1:0] raw_value,
  input  logic [2:0]       raw_mode,
  input  logic             raw_bcd,
  output logic [CW-1:0]    init_value,
  output pcc_mode_e        mode
);
  localparam logic [CW-1:0] BIN_FULL = CW'(1) << CNT_W;
  localparam logic [CW-1:0] DEC_FULL = CW'(pow10(DIG));

  logic [CW-1:0] dec_acc;

  always_comb begin
    dec_acc = '0;
    for (int i = DIG - 1; i >= 0; i--)
      dec_acc = dec_acc * CW'(10) + CW'(raw_value[i*4 +: 4]);
    if (raw_value == '0) init_value = raw_bcd ? DEC_FULL : BIN_FULL;
    else                 init_value = raw_bcd ? dec_acc : {1'b0, raw_value};
  end

  always_comb begin
    unique case (raw_mode)
      3'd6:    mode = MD_DIVIDER;
      3'd7:    mode = MD_SQUARE;
      default: mode = pcc_mode_e'(raw_mode);
    endcase
  end
endmodule

// File: rtl/pcc_count_view.sv
`timescale 1ns/1ps
module pcc_count_view
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int CW = CNT_W + 1,
  localparam int DIG = CNT_W / 4
) (
  input  logic [CW-1:0]    cnt,
  input  logic             bcd,
  output logic [CNT_W-1:0] view
);
  localparam logic [CW-1:0] DEC_MOD = CW'(pow10(DIG));

  logic [CW-1:0]    rem;
  logic [CNT_W-1:0] dec_digits;

  always_comb begin
    rem = cnt % DEC_MOD;
    dec_digits = '0;
    for (int i = 0; i < DIG; i++) begin
      dec_digits[i*4 +: 4] = 4'(rem % CW'(10));
      rem = rem / CW'(10);
    end
    view = bcd ? dec_digits : cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/pcc_count_engine.sv
`timescale 1ns/1ps
module pcc_count_engine
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic GATE_RST = 1'b1,
  localparam int CW = CNT_W + 1,
  localparam int DIG = CNT_W / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate_in,
  input  logic          load_valid,
  input  logic [CW-1:0] ld_init,
  input  pcc_mode_e     ld_mode,
  input  logic          ld_bcd,
  output logic [CW-1:0] cnt,
  output logic          bcd,
  output logic          out_level
);
  localparam logic [CW-1:0] BIN_WRAP = (CW'(1) << CNT_W) - CW'(1);
  localparam logic [CW-1:0] DEC_WRAP = CW'(pow10(DIG)) - CW'(1);

  pcc_mode_e     mode_q;
  logic [CW-1:0] init_q, cnt_q;
  logic          bcd_q, out_q, running, armed, phase_hi, gate_q;

  logic          gate_rise, retrig_mode, freeze_mode, restart, adv;
  pcc_mode_e     sel_mode;
  logic [CW-1:0] sel_init, start_val, dec_val, wrap_max, hi_load, lo_load;
  logic          start_out;

  always_comb begin
    gate_rise   = gate_in & ~gate_q;
    retrig_mode = mode_q inside {MD_ONESHOT, MD_DIVIDER, MD_SQUARE, MD_GATE_STROBE};
    freeze_mode = mode_q inside {MD_TERMINAL, MD_SOFT_STROBE};
    restart     = load_valid | (running & gate_rise & retrig_mode);
    adv         = running & tick_en & (gate_in | ~freeze_mode);
    sel_mode    = load_valid ? ld_mode : mode_q;
    sel_init    = load_valid ? ld_init : init_q;
    start_val   = (sel_mode == MD_SQUARE) ? sel_init + CW'(sel_init[0]) : sel_init;
    start_out   = sel_mode inside {MD_ONESHOT, MD_SQUARE};
    wrap_max    = bcd_q ? DEC_WRAP : BIN_WRAP;
    dec_val     = (cnt_q == '0) ? wrap_max : cnt_q - CW'(1);
    hi_load     = init_q + CW'(init_q[0]);
    lo_load     = init_q - CW'(init_q[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MD_TERMINAL;
      init_q   <= '0;
      cnt_q    <= '0;
      bcd_q    <= 1'b0;
      out_q    <= 1'b0;
      running  <= 1'b0;
      armed    <= 1'b0;
      phase_hi <= 1'b0;
      gate_q   <= GATE_RST;
    end else begin
      gate_q <= gate_in;
      if (load_valid) begin
        mode_q <= ld_mode;
        init_q <= ld_init;
        bcd_q  <= ld_bcd;
      end
      if (restart) begin
        cnt_q    <= start_val;
        out_q    <= start_out;
        armed    <= 1'b1;
        phase_hi <= 1'b1;
        running  <= 1'b1;
      end else if (adv) begin
        unique case (mode_q)
          MD_DIVIDER: begin
            if (cnt_q == CW'(1)) begin
              cnt_q <= init_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - CW'(1);
              out_q <= 1'b0;
            end
          end
          MD_SQUARE: begin
            if (cnt_q <= CW'(2)) begin
              if (phase_hi && lo_load != '0) begin
                cnt_q    <= lo_load;
                out_q    <= 1'b0;
                phase_hi <= 1'b0;
              end else begin
                cnt_q    <= hi_load;
                out_q    <= 1'b1;
                phase_hi <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q - CW'(2);
            end
          end
          default: begin
            cnt_q <= dec_val;
            if (dec_val == '0 && armed) begin
              armed <= 1'b0;
              out_q <= (mode_q != MD_ONESHOT);
            end else if (mode_q inside {MD_SOFT_STROBE, MD_GATE_STROBE}) begin
              out_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign cnt       = cnt_q;
  assign bcd       = bcd_q;
  assign out_level = out_q;

  // R9
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {MD_SOFT_STROBE, MD_GATE_STROBE} && out_q && adv && !load_valid) |=> !out_q);

  // R5
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TERMINAL && out_q && !load_valid) |=> out_q);

  // R7
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode_q inside {MD_DIVIDER, MD_SQUARE} && !load_valid) |=> (cnt_q <= init_q + CW'(1)));

  // R10
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_mode && !gate_in && !load_valid) |=> ($stable(cnt_q) && $stable(out_q)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_valid) |=> $stable(cnt_q));
endmodule

// File: rtl/prog_count_channel.sv
`timescale 1ns/1ps
module prog_count_channel
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic GATE_RST = 1'b1,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             load_valid,
  input  logic [CNT_W-1:0] load_value,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  output logic [CNT_W-1:0] count_out,
  output logic             out_level
);
  logic [CW-1:0] ld_init, cnt;
  pcc_mode_e     ld_mode;
  logic          bcd;

  pcc_load_decode #(.CNT_W(CNT_W)) u_decode (
    .raw_value (load_value),
    .raw_mode  (load_mode),
    .raw_bcd   (load_bcd),
    .init_value(ld_init),
    .mode      (ld_mode)
  );

  pcc_count_engine #(.CNT_W(CNT_W), .GATE_RST(GATE_RST)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .gate_in   (gate_in),
    .load_valid(load_valid),
    .ld_init   (ld_init),
    .ld_mode   (ld_mode),
    .ld_bcd    (load_bcd),
    .cnt       (cnt),
    .bcd       (bcd),
    .out_level (out_level)
  );

  pcc_count_view #(.CNT_W(CNT_W)) u_view (
    .cnt (cnt),
    .bcd (bcd),
    .view(count_out)
  );

  // R10
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_valid && !gate_in) |=> ($stable(count_out) && $stable(out_level)));
endmodule

// File: tb/prog_count_channel_bench.sv
`timescale 1ns/1ps
module prog_count_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, gate_in = 1'b1, load_valid = 1'b0, load_bcd = 1'b0;
  logic [15:0] load_value = '0;
  logic [2:0]  load_mode = '0;
  logic [15:0] count_out;
  logic        out_level;

  typedef struct {
    logic [15:0] cnt;
    logic        out;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0;
  logic g_gate = 1'b1;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  prog_count_channel u_prog_count_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_valid(load_valid), .load_value(load_value), .load_mode(load_mode),
    .load_bcd(load_bcd), .count_out(count_out), .out_level(out_level)
  );

  // Monitor: pops one expectation per driven cycle, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (count_out !== e.cnt || out_level !== e.out) begin
          fails++;
          $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                   e.tag, count_out, out_level, e.cnt, e.out);
        end
      end
    end
  end

  task automatic step(input logic tk, input logic ld, input logic [15:0] lv,
                      input logic [2:0] lm, input logic lb,
                      input logic [15:0] ec, input logic eo, input string tag);
    @(negedge clk);
    tick_en = tk; load_valid = ld; load_value = lv; load_mode = lm; load_bcd = lb;
    gate_in = g_gate;
    exp_q.push_back('{cnt: ec, out: eo, tag: tag});
  endtask

  task automatic do_load(input logic [15:0] v, input logic [2:0] m, input logic b,
                         input logic [15:0] ec, input logic eo, input string tag);
    step(1'b0, 1'b1, v, m, b, ec, eo, tag);
  endtask

  task automatic do_tick(input logic [15:0] ec, input logic eo, input string tag);
    step(1'b1, 1'b0, '0, '0, 1'b0, ec, eo, tag);
  endtask

  task automatic do_idle(input logic [15:0] ec, input logic eo, input string tag);
    step(1'b0, 1'b0, '0, '0, 1'b0, ec, eo, tag);
  endtask

  task automatic do_gate(input logic g, input logic [15:0] ec, input logic eo, input string tag);
    g_gate = g;
    step(1'b0, 1'b0, '0, '0, 1'b0, ec, eo, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, ticks ignored before any load
    do_idle(16'h0000, 1'b0, "R1 reset");
    do_tick(16'h0000, 1'b0, "R1 tick before load");

    // R5 / R4 / R10 / R11: mode 0, N=3
    do_load(16'd3, 3'd0, 1'b0, 16'd3, 1'b0, "R5 load");
    do_tick(16'd2, 1'b0, "R5 count");
    do_tick(16'd1, 1'b0, "R5 count");
    do_tick(16'd0, 1'b1, "R5 terminal");
    do_tick(16'hFFFF, 1'b1, "R4 wrap binary");
    do_tick(16'hFFFE, 1'b1, "R5 sticky");
    do_gate(1'b0, 16'hFFFE, 1'b1, "R10 gate low");
    do_tick(16'hFFFE, 1'b1, "R10 frozen");
    do_gate(1'b1, 16'hFFFE, 1'b1, "R11 no restart mode0");
    do_tick(16'hFFFD, 1'b1, "R10 resumes");
    do_load(16'd5, 3'd0, 1'b0, 16'd5, 1'b0, "R12 reload restarts");

    // R6 / R11: mode 1, N=2
    do_load(16'd2, 3'd1, 1'b0, 16'd2, 1'b1, "R6 load");
    do_tick(16'd1, 1'b1, "R6 count");
    do_tick(16'd0, 1'b0, "R6 terminal");
    do_tick(16'hFFFF, 1'b0, "R6 stays low");
    do_gate(1'b0, 16'hFFFF, 1'b0, "R6 gate low");
    do_gate(1'b1, 16'd2, 1'b1, "R11 retrigger mode1");
    do_tick(16'd1, 1'b1, "R6 after retrigger");

    // R7: mode 2, N=3
    do_load(16'd3, 3'd2, 1'b0, 16'd3, 1'b0, "R7 load");
    do_tick(16'd2, 1'b0, "R7 count");
    do_tick(16'd1, 1'b0, "R7 count");
    do_tick(16'd3, 1'b1, "R7 reload pulse");
    do_tick(16'd2, 1'b0, "R7 pulse ends");
    do_tick(16'd1, 1'b0, "R7 count");
    do_tick(16'd3, 1'b1, "R7 second pulse");

    // R12: mode code 6 acts as mode 2
    do_load(16'd2, 3'd6, 1'b0, 16'd2, 1'b0, "R12 code6 load");
    do_tick(16'd1, 1'b0, "R12 code6");
    do_tick(16'd2, 1'b1, "R12 code6 pulse");
    do_tick(16'd1, 1'b0, "R12 code6");

    // R8: mode 3, N=4 (2 high, 2 low)
    do_load(16'd4, 3'd3, 1'b0, 16'd4, 1'b1, "R8 even load");
    do_tick(16'd2, 1'b1, "R8 even high");
    do_tick(16'd4, 1'b0, "R8 even low half");
    do_tick(16'd2, 1'b0, "R8 even low");
    do_tick(16'd4, 1'b1, "R8 even high again");

    // R8: mode 3, N=5 (3 high, 2 low)
    do_load(16'd5, 3'd3, 1'b0, 16'd6, 1'b1, "R8 odd load");
    do_tick(16'd4, 1'b1, "R8 odd high");
    do_tick(16'd2, 1'b1, "R8 odd high");
    do_tick(16'd4, 1'b0, "R8 odd low half");
    do_tick(16'd2, 1'b0, "R8 odd low");
    do_tick(16'd6, 1'b1, "R8 odd high again");

    // R8 / R12: mode code 7, N=1 stays high
    do_load(16'd1, 3'd7, 1'b0, 16'd2, 1'b1, "R12 code7 load");
    do_tick(16'd2, 1'b1, "R8 N1 high");
    do_tick(16'd2, 1'b1, "R8 N1 high");

    // R9 / R10 / R11: mode 4, N=2
    do_load(16'd2, 3'd4, 1'b0, 16'd2, 1'b0, "R9 m4 load");
    do_tick(16'd1, 1'b0, "R9 m4 count");
    do_tick(16'd0, 1'b1, "R9 m4 strobe");
    do_tick(16'hFFFF, 1'b0, "R9 m4 strobe ends");
    do_gate(1'b0, 16'hFFFF, 1'b0, "R10 m4 gate low");
    do_tick(16'hFFFF, 1'b0, "R10 m4 frozen");
    do_gate(1'b1, 16'hFFFF, 1'b0, "R11 no restart mode4");

    // R9 / R11: mode 5, N=2
    do_load(16'd2, 3'd5, 1'b0, 16'd2, 1'b0, "R9 m5 load");
    do_tick(16'd1, 1'b0, "R9 m5 count");
    do_tick(16'd0, 1'b1, "R9 m5 strobe");
    do_tick(16'hFFFF, 1'b0, "R9 m5 ends");
    do_gate(1'b0, 16'hFFFF, 1'b0, "R9 m5 gate low");
    do_gate(1'b1, 16'd2, 1'b0, "R11 retrigger mode5");
    do_tick(16'd1, 1'b0, "R11 m5 count");
    do_tick(16'd0, 1'b1, "R11 m5 strobe again");

    // R3: decimal counting
    do_load(16'h0012, 3'd0, 1'b1, 16'h0012, 1'b0, "R3 load bcd");
    do_tick(16'h0011, 1'b0, "R3 count");
    do_tick(16'h0010, 1'b0, "R3 count");
    do_tick(16'h0009, 1'b0, "R3 digit borrow");
    do_load(16'h0010, 3'd2, 1'b1, 16'h0010, 1'b0, "R3 mode2 bcd");
    do_tick(16'h0009, 1'b0, "R3 mode2 borrow");

    // R2: zero loads full span
    do_load(16'h0000, 3'd4, 1'b1, 16'h0000, 1'b0, "R2 bcd zero");
    do_tick(16'h9999, 1'b0, "R2 bcd span");
    do_tick(16'h9998, 1'b0, "R2 bcd span");
    do_load(16'h0000, 3'd0, 1'b0, 16'h0000, 1'b0, "R2 bin zero");
    do_tick(16'hFFFF, 1'b0, "R2 bin span");

    // R4: decimal wrap
    do_load(16'h0002, 3'd0, 1'b1, 16'h0002, 1'b0, "R4 bcd load");
    do_tick(16'h0001, 1'b0, "R4 bcd count");
    do_tick(16'h0000, 1'b1, "R4 bcd terminal");
    do_tick(16'h9999, 1'b1, "R4 bcd wrap");

    do_idle(16'h9999, 1'b1, "R4 hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule